// File: doc/BRIEF.md
# Encoded-Edge Boundary Converter

This block sits where a timing-encoded region meets ordinary single-bit logic. Inside the encoded region, each reference-clock cycle carries a bundle for one signal. The bundle holds a start level and a short list of transition slots. Each slot has a valid flag and an OFS_W-bit offset that places the transition inside the cycle, so one cycle spans 2^OFS_W ticks.

The block has two halves. The entry half samples a plain bit on the reference clock and produces the bundle. The exit half takes a bundle and reduces it to the level the signal holds at the end of the cycle. It can first apply an inertial filter that drops any pulse narrower than MIN_PW ticks, even when the pulse spans a cycle boundary. The exit level reaches the plain output at a point chosen by the UPD_MODE parameter:

- 0: in the same cycle, combinationally.
- 1: at the falling clock edge in the middle of the cycle.
- 2: at the next rising edge.

OFS_W sets the quantisation accuracy. With OFS_W = 1, an entry half looped into an exit half acts as a one-cycle registered wire.

Top module: `edge_boundary_conv`

## Requirements
- R1: The entry half drives its start level with the plain input sampled at the previous rising edge. That stored level is 0 after reset.
- R2: When the plain input differs from the stored level, slot 0 is valid with offset 0. Otherwise no slot is valid, which codes a steady high or low. All other slots are always invalid and all offsets are 0.
- R3: With MIN_PW = 0, the exit level is the start level XOR the number of valid slots, modulo 2.
- R4: With MIN_PW > 0, a pulse is removed when the time between two consecutive transitions is less than MIN_PW ticks. This holds whether the two transitions fall in one cycle or in adjacent cycles, where the next cycle begins 2^OFS_W ticks after the current one. When a pulse is removed, the exit level stays at the level held before it.
- R5: With MIN_PW > 0, a new level is accepted once it has lasted MIN_PW ticks. The exit level is the accepted level at the end of the cycle. A cycle with no transitions that follows another cycle with no transitions leaves the exit level unchanged.
- R6: With UPD_MODE = 0, the plain output equals the exit level of the current cycle.
- R7: With UPD_MODE = 1, the plain output takes the current exit level at the falling clock edge. Before that edge it still shows the previous cycle's value.
- R8: With UPD_MODE = 2, the plain output takes the exit level at the rising edge that ends the cycle.
- R9: While reset is asserted, the plain output, the stored entry level and the accepted filter level are all 0.
- R10: With OFS_W = 1, an entry half looped into an exit half in UPD_MODE = 2 reproduces the plain input one cycle later.
- R11: Valid slots must fill from slot 0 upward and their offsets must not decrease. Slot i uses offset bits [i*OFS_W +: OFS_W]. Two transitions at the same offset form a zero-width pulse, which is removed whenever MIN_PW >= 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| plain_i | input | 1 | Plain bit entering the encoded region |
| enc_start_o | output | 1 | Start level of the produced bundle |
| enc_vld_o | output | N_EDGE | Slot valid flags of the produced bundle |
| enc_ofs_o | output | N_EDGE*OFS_W | Slot offsets of the produced bundle |
| dec_start_i | input | 1 | Start level of the incoming bundle |
| dec_vld_i | input | N_EDGE | Slot valid flags of the incoming bundle |
| dec_ofs_i | input | N_EDGE*OFS_W | Slot offsets of the incoming bundle |
| plain_o | output | 1 | Plain bit leaving the encoded region |

## Verification
Some properties are checked by assertions on every cycle:

- The stored start level follows the sampled input.
- Every emitted transition is followed by a change of start level.
- The rising-edge output tracks the exit level.
- Two quiet cycles in a row leave the exit level unchanged.
- Incoming bundles keep their slots packed and their offsets sorted.

Other behaviour can only be shown by the bench's scenarios, because no single-cycle property captures it:

- Narrow pulses that cross a cycle boundary are removed, and late transitions are accepted only in the following cycle.
- The falling-edge mode updates in mid-cycle.
- The one-bit loopback acts as a registered wire.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

   // Output update point selection
   localparam int UPD_ZERO = 0;
   localparam int UPD_FALL = 1;
   localparam int UPD_RISE = 2;

   // Largest supported offset width
   localparam int OFS_W_MAX = 16;

   // Number of ticks in one reference cycle
   function automatic int cycle_ticks(input int ofs_w);
      return 1 << ofs_w;
   endfunction

endpackage

// File: rtl/ebc_enc.sv
// Entry half: plain bit -> start level plus transition slots
module ebc_enc #(
   parameter int OFS_W  = 4,
   parameter int N_EDGE = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    din,
   output logic                    start_o,
   output logic [N_EDGE-1:0]       vld_o,
   output logic [N_EDGE*OFS_W-1:0] ofs_o
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= din;
   end

   assign start_o = prev_q;

   // A change is placed at tick zero of slot 0
   always_comb begin
      vld_o    = '0;
      vld_o[0] = din ^ prev_q;
      ofs_o    = '0;
   end

endmodule

// File: rtl/ebc_parity_dec.sv
// Exit half without filtering: level at cycle end by transition parity
module ebc_parity_dec #(
   parameter int N_EDGE = 4
) (
   input  logic              start_i,
   input  logic [N_EDGE-1:0] vld_i,
   output logic              lvl_o
);

   assign lvl_o = start_i ^ (^vld_i);

endmodule

// File: rtl/ebc_inertial_dec.sv
// Exit half with inertial filtering across cycle boundaries
module ebc_inertial_dec #(
   parameter int OFS_W  = 4,
   parameter int N_EDGE = 4,
   parameter int MIN_PW = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [N_EDGE-1:0]       vld_i,
   input  logic [N_EDGE*OFS_W-1:0] ofs_i,
   output logic                    lvl_o
);

   // Deadlines reach up to two cycles of ticks
   localparam int            TW   = OFS_W + 2;
   localparam logic [TW-1:0] CYC  = TW'(ebc_pkg::cycle_ticks(OFS_W));
   localparam logic [TW-1:0] MINV = TW'(MIN_PW);

   logic          acc_q, acc_d;
   logic [TW-1:0] dl_q, dl_d;

   always_comb begin
      logic          a, p;
      logic [TW-1:0] d, e;
      a = acc_q;
      // Raw level differs from accepted level: a change is still pending
      p = start_i ^ acc_q;
      d = dl_q;
      e = '0;
      for (int i = 0; i < N_EDGE; i++) begin
         if (vld_i[i]) begin
            e = TW'(ofs_i[i*OFS_W +: OFS_W]);
            if (p && (e < d)) begin
               p = 1'b0;            // too narrow: drop the pulse
            end else begin
               if (p) a = ~a;       // pending level lasted long enough
               p = 1'b1;
               d = e + MINV;
            end
         end
      end
      if (p && (d <= CYC)) begin
         a = ~a;
         p = 1'b0;
      end
      acc_d = a;
      dl_d  = p ? (d - CYC) : '0;
      lvl_o = a;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= 1'b0;
         dl_q  <= '0;
      end else begin
         acc_q <= acc_d;
         dl_q  <= dl_d;
      end
   end

endmodule

// File: rtl/edge_boundary_conv.sv
module edge_boundary_conv #(
   parameter int OFS_W    = 4,
   parameter int N_EDGE   = 4,
   parameter int UPD_MODE = 2,
   parameter int MIN_PW   = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    plain_i,
   output logic                    enc_start_o,
   output logic [N_EDGE-1:0]       enc_vld_o,
   output logic [N_EDGE*OFS_W-1:0] enc_ofs_o,
   input  logic                    dec_start_i,
   input  logic [N_EDGE-1:0]       dec_vld_i,
   input  logic [N_EDGE*OFS_W-1:0] dec_ofs_i,
   output logic                    plain_o
);

   localparam int TICKS = ebc_pkg::cycle_ticks(OFS_W);

   // Elaboration-time parameter checks
   if (OFS_W < 1 || OFS_W > ebc_pkg::OFS_W_MAX) begin : g_bad_w
      $error("edge_boundary_conv: OFS_W out of range");
   end
   if (N_EDGE < 1) begin : g_bad_n
      $error("edge_boundary_conv: N_EDGE must be at least 1");
   end
   if (MIN_PW < 0 || MIN_PW > TICKS) begin : g_bad_pw
      $error("edge_boundary_conv: MIN_PW must lie in 0..2**OFS_W");
   end
   if (UPD_MODE != ebc_pkg::UPD_ZERO && UPD_MODE != ebc_pkg::UPD_FALL &&
       UPD_MODE != ebc_pkg::UPD_RISE) begin : g_bad_mode
      $error("edge_boundary_conv: unknown UPD_MODE");
   end

   logic fin_lvl;

   ebc_enc #(.OFS_W(OFS_W), .N_EDGE(N_EDGE)) u_enc (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (plain_i),
      .start_o (enc_start_o),
      .vld_o   (enc_vld_o),
      .ofs_o   (enc_ofs_o)
   );

   if (MIN_PW == 0) begin : g_nofilt
      ebc_parity_dec #(.N_EDGE(N_EDGE)) u_dec (
         .start_i (dec_start_i),
         .vld_i   (dec_vld_i),
         .lvl_o   (fin_lvl)
      );
   end else begin : g_filt
      ebc_inertial_dec #(.OFS_W(OFS_W), .N_EDGE(N_EDGE), .MIN_PW(MIN_PW)) u_dec (
         .clk     (clk),
         .rst_n   (rst_n),
         .start_i (dec_start_i),
         .vld_i   (dec_vld_i),
         .ofs_i   (dec_ofs_i),
         .lvl_o   (fin_lvl)
      );
   end

   if (UPD_MODE == ebc_pkg::UPD_ZERO) begin : g_upd_zero
      assign plain_o = rst_n & fin_lvl;
   end else if (UPD_MODE == ebc_pkg::UPD_FALL) begin : g_upd_fall
      logic out_q;
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) out_q <= 1'b0;
         else        out_q <= fin_lvl;
      end
      assign plain_o = out_q;
   end else begin : g_upd_rise
      logic out_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_q <= 1'b0;
         else        out_q <= fin_lvl;
      end
      assign plain_o = out_q;
   end

endmodule

// File: rtl/edge_boundary_conv_chk.sv
module edge_boundary_conv_chk #(
   parameter int OFS_W    = 4,
   parameter int N_EDGE   = 4,
   parameter int UPD_MODE = 2,
   parameter int MIN_PW   = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    plain_i,
   input logic                    enc_start_o,
   input logic [N_EDGE-1:0]       enc_vld_o,
   input logic                    dec_start_i,
   input logic [N_EDGE-1:0]       dec_vld_i,
   input logic [N_EDGE*OFS_W-1:0] dec_ofs_i,
   input logic                    plain_o,
   input logic                    fin_lvl
);

   // R1: stored start level follows the sampled plain input
   assert_enc_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> enc_start_o == $past(plain_i))
      else $error("assert_enc_start_R1");

   // R2: an emitted transition flips the next start level
   assert_enc_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
      enc_vld_o[0] |=> enc_start_o != $past(enc_start_o))
      else $error("assert_enc_flip_R2");

   if (UPD_MODE == ebc_pkg::UPD_RISE) begin : g_rise
      // R8: rising-edge output carries the previous cycle's exit level
      assert_out_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> plain_o == $past(fin_lvl))
         else $error("assert_out_rise_R8");
   end

   if (MIN_PW > 0) begin : g_hold
      // R5: two quiet cycles leave the exit level unchanged
      assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_vld_i == '0 && $past(dec_vld_i) == '0 && $stable(dec_start_i))
         |-> $stable(fin_lvl))
         else $error("assert_quiet_hold_R5");
   end else begin : g_par
      // R3: no transitions means the start level is the exit level
      assert_quiet_par_R3: assert property (@(posedge clk) disable iff (!rst_n)
         dec_vld_i == '0 |-> fin_lvl == dec_start_i)
         else $error("assert_quiet_par_R3");
   end

   for (genvar i = 0; i + 1 < N_EDGE; i++) begin : g_slot
      // R11: slots fill from 0 and offsets never decrease
      assert_vld_packed_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !dec_vld_i[i] |-> !dec_vld_i[i+1])
         else $error("assert_vld_packed_R11");
      assert_ofs_sorted_R11: assert property (@(posedge clk) disable iff (!rst_n)
         dec_vld_i[i+1] |->
            dec_ofs_i[(i+1)*OFS_W +: OFS_W] >= dec_ofs_i[i*OFS_W +: OFS_W])
         else $error("assert_ofs_sorted_R11");
   end

endmodule

bind edge_boundary_conv edge_boundary_conv_chk #(
   .OFS_W(OFS_W), .N_EDGE(N_EDGE), .UPD_MODE(UPD_MODE), .MIN_PW(MIN_PW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .plain_i     (plain_i),
   .enc_start_o (enc_start_o),
   .enc_vld_o   (enc_vld_o),
   .dec_start_i (dec_start_i),
   .dec_vld_i   (dec_vld_i),
   .dec_ofs_i   (dec_ofs_i),
   .plain_o     (plain_o),
   .fin_lvl     (fin_lvl)
);

// File: tb/edge_boundary_conv_bench.sv
`timescale 1ns/1ps
module edge_boundary_conv_bench;

   localparam int W    = 4;
   localparam int N    = 4;
   localparam int MINP = 3;
   localparam int TK   = 1 << W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // filtered, rising-edge update
   logic         d_pin = 1'b0, d_enc_st, d_st = 1'b0, d_out;
   logic [N-1:0] d_enc_v, d_v = '0;
   logic [N*W-1:0] d_enc_o, d_o = '0;
   // unfiltered, same-cycle update
   logic         r_out, r_enc_st;
   logic [N-1:0] r_enc_v;
   logic [N*W-1:0] r_enc_o;
   // unfiltered, falling-edge update
   logic         f_out, f_enc_st;
   logic [N-1:0] f_enc_v;
   logic [N*W-1:0] f_enc_o;
   // one-bit offsets, looped back
   logic       w_pin = 1'b0, w_st, w_out;
   logic [1:0] w_v, w_o;

   edge_boundary_conv u_edge_boundary_conv (
      .clk(clk), .rst_n(rst_n), .plain_i(d_pin),
      .enc_start_o(d_enc_st), .enc_vld_o(d_enc_v), .enc_ofs_o(d_enc_o),
      .dec_start_i(d_st), .dec_vld_i(d_v), .dec_ofs_i(d_o), .plain_o(d_out));

   edge_boundary_conv #(.OFS_W(W), .N_EDGE(N), .UPD_MODE(0), .MIN_PW(0)) u_edge_boundary_conv_raw (
      .clk(clk), .rst_n(rst_n), .plain_i(1'b0),
      .enc_start_o(r_enc_st), .enc_vld_o(r_enc_v), .enc_ofs_o(r_enc_o),
      .dec_start_i(d_st), .dec_vld_i(d_v), .dec_ofs_i(d_o), .plain_o(r_out));

   edge_boundary_conv #(.OFS_W(W), .N_EDGE(N), .UPD_MODE(1), .MIN_PW(0)) u_edge_boundary_conv_fall (
      .clk(clk), .rst_n(rst_n), .plain_i(1'b0),
      .enc_start_o(f_enc_st), .enc_vld_o(f_enc_v), .enc_ofs_o(f_enc_o),
      .dec_start_i(d_st), .dec_vld_i(d_v), .dec_ofs_i(d_o), .plain_o(f_out));

   edge_boundary_conv #(.OFS_W(1), .N_EDGE(2), .UPD_MODE(2), .MIN_PW(1)) u_edge_boundary_conv_w1 (
      .clk(clk), .rst_n(rst_n), .plain_i(w_pin),
      .enc_start_o(w_st), .enc_vld_o(w_v), .enc_ofs_o(w_o),
      .dec_start_i(w_st), .dec_vld_i(w_v), .dec_ofs_i(w_o), .plain_o(w_out));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   initial begin
      #(1_500_000ns);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit   prev, din, raw, par_prev, have_prev;
      bit   r_acc, r_pend;
      int   r_pt, cyc, k, t, exp_prev;
      int   o[4];

      // reset state (R9)
      repeat (3) @(posedge clk);
      #1;
      chk(d_out == 1'b0, "R9 rise out", d_out, 0);
      chk(f_out == 1'b0, "R9 fall out", f_out, 0);
      chk(w_out == 1'b0, "R9 loop out", w_out, 0);
      chk(d_enc_st == 1'b0, "R9 stored entry level", d_enc_st, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // entry half and one-bit loopback (R1 R2 R10)
      prev = 1'b0;
      for (int i = 0; i < 2000; i++) begin
         @(posedge clk);
         #1;
         if (i > 0) chk(w_out == din, "R10 loopback", w_out, din);
         din   = 1'($urandom_range(0, 1));
         if (i % 97 < 10) din = prev;   // steady runs
         d_pin = din;
         w_pin = din;
         @(negedge clk);
         #1;
         chk(d_enc_st == prev, "R1 start level", d_enc_st, prev);
         chk(d_enc_v == N'(din != prev), "R2 slot flags", d_enc_v, din != prev);
         chk(d_enc_o == '0, "R2 offsets", int'(d_enc_o), 0);
         prev = din;
      end

      // sweep of sorted offset tuples with 0..4 valid slots (R3..R8 R11)
      @(posedge clk);
      #1;
      raw = 1'b0; r_acc = 1'b0; r_pend = 1'b0; r_pt = 0; cyc = 0;
      have_prev = 1'b0; par_prev = 1'b0; exp_prev = 0;
      for (int code = 0; code < 65536; code++) begin
         o[0] = code & 15;
         o[1] = (code >> 4) & 15;
         o[2] = (code >> 8) & 15;
         o[3] = (code >> 12) & 15;
         if (o[0] <= o[1] && o[1] <= o[2] && o[2] <= o[3]) begin
            for (k = 0; k <= N; k++) begin
               @(posedge clk);
               #1;
               if (have_prev) begin
                  chk(d_out == exp_prev[0], "R4 R5 R8 R11 filtered rise out", d_out, exp_prev);
                  chk(f_out == par_prev, "R7 fall out before mid-cycle", f_out, par_prev);
               end
               d_st = raw;
               d_v  = N'((1 << k) - 1);
               d_o  = {4'(o[3]), 4'(o[2]), 4'(o[1]), 4'(o[0])};
               // reference: inertial filter in absolute ticks
               for (int j = 0; j < k; j++) begin
                  t = cyc * TK + o[j];
                  if (r_pend && (t - r_pt) < MINP) r_pend = 1'b0;
                  else begin
                     if (r_pend) r_acc = ~r_acc;
                     r_pend = 1'b1;
                     r_pt   = t;
                  end
               end
               if (r_pend && ((cyc + 1) * TK - r_pt) >= MINP) begin
                  r_acc  = ~r_acc;
                  r_pend = 1'b0;
               end
               cyc++;
               raw = raw ^ k[0];
               @(negedge clk);
               #1;
               chk(r_out == raw, "R3 R6 same-cycle parity", r_out, raw);
               chk(f_out == raw, "R7 fall out after mid-cycle", f_out, raw);
               exp_prev  = int'(r_acc);
               par_prev  = raw;
               have_prev = 1'b1;
            end
         end
      end
      @(posedge clk);
      #1;
      chk(d_out == exp_prev[0], "R4 R5 R8 final", d_out, exp_prev);

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule